// File: doc/BRIEF.md
# Miss Source History Predictor

This block learns, separately for instruction (code) fetches and data accesses, how recent last-level cache misses were filled. A fill can come from another cache (cache-to-cache) or from memory. Each fill is recorded as one bit in a 64-entry shift history for its class.

From that history the block gives two pieces of advice for a miss of a queried class. The first is the request mode: a broadcast peer-to-peer request when cache-to-cache fills dominate, or a unicast mediated request toward the coherence gateway otherwise. The second is whether to launch a speculative memory prefetch alongside the request.

The requesting logic reports every completed fill on the fill inputs. When a new miss is about to go out, it drives the query class and reads the advice in the same cycle. The thresholds are elaboration parameters. Building and issuing the requests is outside this block.

Top module: `miss_src_predictor`

## Requirements
- R1: After reset both class histories hold no cache-to-cache fills, so for either query class `query_p2p` is 0 (mediated) and `query_prefetch` is 1.
- R2: When `fill_valid` is 1 on a clock edge, a 1 (`fill_from_cache`=1, cache-to-cache) or a 0 (`fill_from_cache`=0, memory) is shifted into the history selected by `fill_is_code` (1 = code, 0 = data). The history of the other class is not changed.
- R3: `query_p2p` is 1 exactly when the number of cache-to-cache fills in the queried history is at least P2P_THRESH (default 32). With the default, 31 gives 0 and 32 gives 1.
- R4: `query_prefetch` is 1 exactly when the number of memory fills in the queried history is at least PF_THRESH (default 48). With the default, 16 cache-to-cache fills out of 64 gives 1 and 17 gives 0.
- R5: Only the most recent DEPTH (default 64) fills of a class count. A newer fill pushes the oldest one out of the window.
- R6: While `fill_valid` is 0, no history changes, whatever the values on `fill_is_code` and `fill_from_cache`.
- R7: The advice is a combinational function of `query_is_code` (1 = code, 0 = data) and the stored histories. A fill taken at a clock edge is reflected in the advice right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_valid | input | 1 | A miss fill completed this cycle |
| fill_is_code | input | 1 | Class of the fill: 1 code, 0 data |
| fill_from_cache | input | 1 | Source of the fill: 1 cache-to-cache, 0 memory |
| query_is_code | input | 1 | Class being asked about: 1 code, 0 data |
| query_p2p | output | 1 | 1 broadcast peer-to-peer, 0 unicast mediated |
| query_prefetch | output | 1 | 1 launch a speculative memory prefetch |

## Verification
A wrong internal state has two likely forms: a running count that has drifted from the bits it summarises, or a fill that landed in the wrong class. Either one shows up at the ports as an advice bit that flips one fill too early or too late at a threshold crossing. It can also show up when the oldest fill ages out of the window. For that reason the stimulus walks each count exactly across both thresholds, and it pushes whole windows of one source to force ageing. Both classes are read back after every burst, and the error appears in the advice on the first cycle after the offending fill edge.

// File: rtl/msp_pkg.sv
// Shared types for the miss source history predictor.
// Assumes two tracked classes: data (index 0) and code (index 1).
package msp_pkg;
    localparam int NCLS = 2;

    typedef enum logic {
        CLS_DATA = 1'b0,
        CLS_CODE = 1'b1
    } cls_e;

    typedef enum logic {
        SRC_MEM = 1'b0,
        SRC_C2C = 1'b1
    } src_e;

    typedef struct packed {
        logic p2p;
        logic prefetch;
    } advice_t;
endpackage

// File: rtl/msp_history.sv
// Shift history of fill sources for one class, newest fill at bit 0.
// It also keeps a running count of the 1 bits (cache-to-cache fills),
// so no wide popcount sits on the query path.
// Assumes CW is wide enough to hold the value DEPTH.
module msp_history #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [DEPTH-1:0] hist,
    output logic [CW-1:0]    c2c_cnt
);
    logic [CW-1:0] cnt_next;

    // Count update: add the incoming bit and remove the bit falling off the end.
    always_comb begin
        cnt_next = c2c_cnt + CW'(bit_in) - CW'(hist[DEPTH-1]);
    end

    // History and count registers, cleared to "all memory fills" on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist    <= '0;
            c2c_cnt <= '0;
        end else if (shift_en) begin
            hist    <= {hist[DEPTH-2:0], bit_in};
            c2c_cnt <= cnt_next;
        end
    end
endmodule

// File: rtl/msp_decide.sv
// Turns a cache-to-cache fill count into request-mode and prefetch advice.
// Purely combinational. Assumes both thresholds lie in 0..DEPTH.
module msp_decide
    import msp_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int CW         = $clog2(DEPTH + 1),
    parameter int P2P_THRESH = 32,
    parameter int PF_THRESH  = 48
) (
    input  logic [CW-1:0] c2c_cnt,
    output advice_t       advice
);
    localparam logic [CW-1:0] P2P_TH = CW'(P2P_THRESH);
    localparam logic [CW-1:0] PF_TH  = CW'(PF_THRESH);
    localparam logic [CW-1:0] FULL   = CW'(DEPTH);

    logic [CW-1:0] mem_cnt;

    // Compare both source counts against their thresholds.
    always_comb begin
        mem_cnt         = FULL - c2c_cnt;
        advice.p2p      = (c2c_cnt >= P2P_TH);
        advice.prefetch = (mem_cnt >= PF_TH);
    end
endmodule

// File: rtl/miss_src_predictor.sv
// Top of the miss source history predictor.
// Routes each fill event to the history of its class (one history per
// class, built by generate) and answers a query for either class.
// Assumes at most one fill per cycle; a query is answered combinationally.
module miss_src_predictor
    import msp_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int P2P_THRESH = 32,
    parameter int PF_THRESH  = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fill_valid,
    input  logic fill_is_code,
    input  logic fill_from_cache,
    input  logic query_is_code,
    output logic query_p2p,
    output logic query_prefetch
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [NCLS-1:0]  shift_en;
    logic [DEPTH-1:0] hist_arr [NCLS];
    logic [CW-1:0]    cnt_arr  [NCLS];
    advice_t          adv_arr  [NCLS];
    advice_t          adv_sel;

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        // Steer the fill to the history whose class index matches.
        always_comb begin
            shift_en[g] = fill_valid && (fill_is_code == g[0]);
        end

        msp_history #(
            .DEPTH (DEPTH),
            .CW    (CW)
        ) u_hist (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en[g]),
            .bit_in   (fill_from_cache),
            .hist     (hist_arr[g]),
            .c2c_cnt  (cnt_arr[g])
        );

        msp_decide #(
            .DEPTH      (DEPTH),
            .CW         (CW),
            .P2P_THRESH (P2P_THRESH),
            .PF_THRESH  (PF_THRESH)
        ) u_dec (
            .c2c_cnt (cnt_arr[g]),
            .advice  (adv_arr[g])
        );
    end

    // Pick the advice of the queried class.
    always_comb begin
        adv_sel        = query_is_code ? adv_arr[CLS_CODE] : adv_arr[CLS_DATA];
        query_p2p      = adv_sel.p2p;
        query_prefetch = adv_sel.prefetch;
    end
endmodule

// File: rtl/msp_checker.sv
// Property checker for miss_src_predictor, attached by bind.
// Watches the fill ports, the query outputs and both class histories.
module msp_checker #(
    parameter int DEPTH      = 64,
    parameter int CW         = $clog2(DEPTH + 1),
    parameter int P2P_THRESH = 32,
    parameter int PF_THRESH  = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fill_valid,
    input logic             fill_is_code,
    input logic             fill_from_cache,
    input logic             query_is_code,
    input logic             query_p2p,
    input logic             query_prefetch,
    input logic [DEPTH-1:0] hist_code,
    input logic [DEPTH-1:0] hist_data,
    input logic [CW-1:0]    cnt_code,
    input logic [CW-1:0]    cnt_data
);
    // R2
    code_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_is_code) |=>
            (hist_code[0] == $past(fill_from_cache)) &&
            (hist_code[DEPTH-1:1] == $past(hist_code[DEPTH-2:0])) &&
            $stable(hist_data));

    // R2
    data_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_is_code) |=>
            (hist_data[0] == $past(fill_from_cache)) &&
            (hist_data[DEPTH-1:1] == $past(hist_data[DEPTH-2:0])) &&
            $stable(hist_code));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> $stable(hist_code) && $stable(hist_data));

    // R3
    code_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hist_code) == int'(cnt_code));

    // R5
    data_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hist_data) == int'(cnt_data));

    // R3
    p2p_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        query_p2p == ($countones(query_is_code ? hist_code : hist_data) >= P2P_THRESH));

    // R4
    prefetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        query_prefetch ==
            ((DEPTH - $countones(query_is_code ? hist_code : hist_data)) >= PF_THRESH));
endmodule

bind miss_src_predictor msp_checker #(
    .DEPTH      (DEPTH),
    .CW         (CW),
    .P2P_THRESH (P2P_THRESH),
    .PF_THRESH  (PF_THRESH)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .fill_valid      (fill_valid),
    .fill_is_code    (fill_is_code),
    .fill_from_cache (fill_from_cache),
    .query_is_code   (query_is_code),
    .query_p2p       (query_p2p),
    .query_prefetch  (query_prefetch),
    .hist_code       (hist_arr[1]),
    .hist_data       (hist_arr[0]),
    .cnt_code        (cnt_arr[1]),
    .cnt_data        (cnt_arr[0])
);

// File: tb/sim_miss_src_predictor.sv
// Bench for miss_src_predictor: a table of fill bursts with the expected
// advice for both classes, then directed idle and reset tests.
module sim_miss_src_predictor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fill_valid = 1'b0;
    logic fill_is_code = 1'b0;
    logic fill_from_cache = 1'b0;
    logic query_is_code = 1'b0;
    logic query_p2p;
    logic query_prefetch;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    miss_src_predictor u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .fill_valid      (fill_valid),
        .fill_is_code    (fill_is_code),
        .fill_from_cache (fill_from_cache),
        .query_is_code   (query_is_code),
        .query_p2p       (query_p2p),
        .query_prefetch  (query_prefetch)
    );

    // Each entry: [13] code class, [12] from cache, [11:4] burst length,
    // [3:2] expected code {p2p,prefetch}, [1:0] expected data {p2p,prefetch}.
    localparam int NVEC = 9;
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 8'd31, 2'b01, 2'b00},  // R3 data 31 c2c: below p2p
        {1'b0, 1'b1, 8'd1,  2'b01, 2'b10},  // R3 data 32 c2c: p2p
        {1'b1, 1'b1, 8'd16, 2'b01, 2'b10},  // R4 code 16 c2c: prefetch held
        {1'b1, 1'b1, 8'd1,  2'b00, 2'b10},  // R4 code 17 c2c: prefetch off
        {1'b0, 1'b0, 8'd32, 2'b00, 2'b10},  // R5 data still 32 c2c in window
        {1'b0, 1'b0, 8'd1,  2'b00, 2'b00},  // R5 oldest c2c ages out: 31
        {1'b0, 1'b0, 8'd16, 2'b00, 2'b01},  // R5 data 15 c2c: prefetch on
        {1'b1, 1'b0, 8'd64, 2'b01, 2'b01},  // R5 code window all memory
        {1'b1, 1'b1, 8'd64, 2'b10, 2'b01}   // R2 code all c2c, data untouched
    };

    // Apply n back-to-back fills of one class and source.
    task automatic do_fill(input logic is_code, input logic from_cache, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fill_valid      = 1'b1;
            fill_is_code    = is_code;
            fill_from_cache = from_cache;
        end
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Query one class away from the clock edge and compare the advice.
    task automatic check_q(input logic is_code, input logic [1:0] exp, input string tag);
        query_is_code = is_code;
        #1;
        checks++;
        if ({query_p2p, query_prefetch} !== exp) begin
            failures++;
            $display("FAIL %s class=%0b p2p,pf=%b expected %b", tag, is_code,
                     {query_p2p, query_prefetch}, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_q(1'b1, 2'b01, "R1 code during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_q(1'b1, 2'b01, "R1 code after reset");
        check_q(1'b0, 2'b01, "R1 data after reset");

        for (int i = 0; i < NVEC; i++) begin
            do_fill(VEC[i][13], VEC[i][12], int'(VEC[i][11:4]));
            check_q(1'b1, VEC[i][3:2], $sformatf("R7 vec%0d code", i));
            check_q(1'b0, VEC[i][1:0], $sformatf("R7 vec%0d data", i));
        end

        // R7: a single fill shows in the advice right after its edge.
        @(negedge clk);
        fill_valid = 1'b1; fill_is_code = 1'b1; fill_from_cache = 1'b0;
        @(posedge clk);
        #2;
        fill_valid = 1'b0;
        check_q(1'b1, 2'b10, "R7 code 63 c2c still p2p");
        do_fill(1'b1, 1'b0, 31);
        check_q(1'b1, 2'b10, "R3 code 32 c2c");
        do_fill(1'b1, 1'b0, 1);
        check_q(1'b1, 2'b00, "R3 code 31 c2c");

        // R6: idle cycles with toggling side inputs change nothing.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            fill_is_code    = k[0];
            fill_from_cache = ~k[1];
        end
        @(negedge clk);
        check_q(1'b1, 2'b00, "R6 code held");
        check_q(1'b0, 2'b01, "R6 data held");

        // R1: reset in the middle of traffic clears both classes.
        do_fill(1'b0, 1'b1, 40);
        check_q(1'b0, 2'b10, "R2 data refilled c2c");
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_q(1'b0, 2'b01, "R1 data after second reset");
        check_q(1'b1, 2'b01, "R1 code after second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule